// File: doc/BRIEF.md
# Capture/Compare Timer

This block is a 16-bit timer with eight channel slots on a byte-wide register bus. A free-running counter advances by one on every `tick` while the timer is enabled. Each implemented channel is switched by a mode bit between two functions. As an input capture, it stores the counter value when its synchronized input shows the selected transition. As an output compare, it raises a one-cycle pulse on its compare output when the counter reaches the stored value. Either event sets the channel's bit in the channel flag register.

Counter wrap-around sets an overflow flag. Software clears that flag with a one written to it, but only while the timer or the external pulse-accumulator enable is active. When fast-clear is on, any bus access to the counter clears the flag instead. Every 16-bit register is reached as a high byte followed by a low byte. One shadow register and one write buffer keep each 16-bit transfer coherent. Channel slots above the parameter `NCH_IMPL` are reserved.

Register map (byte addresses): 0x00 control (bit 7 timer enable, bit 0 fast-clear); 0x01 mode (bit i = channel i, 1 = compare, 0 = capture); 0x02 edge select for channels 0-3 and 0x03 for channels 4-7 (two bits per channel, channel i at bits [2(i mod 4)+1 : 2(i mod 4)]); 0x04/0x05 counter high/low; 0x06 channel flags (bit i = channel i); 0x07 overflow flag at bit 7; channel x at 0x10+2x (high) and 0x11+2x (low). Read data appears on `bus_rdata` the cycle after `bus_rd`.

Top module: `cct_timer`

## Requirements
- R1: After reset the counter, every channel register, the mode and edge registers and both flag registers read zero, and `cmp_out` is low.
- R2: The counter increments by one on each clock where `tick` is high and control bit 7 is 1. It holds when that bit is 0. A high-then-low byte write to 0x04/0x05 loads it.
- R3: When the counter advances from 0xFFFF to 0x0000, bit 7 of register 0x07 becomes 1 on that same edge.
- R4: Writing 1 to bit 7 of 0x07 clears the overflow flag only if control bit 7 or `pacc_en` is 1. Otherwise the write has no effect.
- R5: With control bit 0 set, any read or write of 0x04 or 0x05 clears the overflow flag. With the bit clear, counter accesses leave the flag unchanged.
- R6: A channel in capture mode samples its input through a two-flop synchronizer. Edge code 00 disables capture, 01 selects rising edges, 10 falling and 11 both. On a selected edge the channel stores the counter value and sets its bit in 0x06.
- R7: A channel in compare mode pulses `cmp_out[i]` for one cycle and sets bit i of 0x06 on the edge where the counter advances to the channel's value.
- R8: Channel registers read back at any time. A bus write changes a channel only while its mode bit is 1. In capture mode the write is ignored.
- R9: A high-byte read of a 16-bit register latches its low byte into a shadow register. The next low-byte read returns the shadow, even if the register has changed in between.
- R10: A high-byte write is held in a buffer and takes effect only when the low byte is written. Both bytes then land together as one 16-bit update.
- R11: Channel x sits at 0x10+2x / 0x11+2x. Slots at or above `NCH_IMPL` ignore writes and read zero.
- R12: Writing 1 to a bit of 0x06 clears that channel flag. Zero bits leave their flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Byte register address |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_rd | input | 1 | Read strobe for one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| tick | input | 1 | Counter advance enable |
| pacc_en | input | 1 | Pulse-accumulator enable, which also permits overflow clearing |
| cap_in | input | 8 | Capture inputs, one per channel slot |
| cmp_out | output | 8 | Compare-match pulses, one per channel slot |

## Verification
The bench steps the counter across 0xFFFF and then tries the overflow clear three ways: with both enables low, through `pacc_en`, and through fast-clear. A design that ignored the enable gating would drop the flag too early, and one without fast-clear would keep it set after a counter read. A tick is inserted between the high and low counter reads, so a design without a shadow register returns the new low byte rather than the latched one. Capture writes, reserved-slot accesses, edge codes that do not match the transition, and a disabled edge code are all driven. Any of them leaking into a channel register would show up in the channel readback. Compare timing is checked on the exact cycle, to catch a pulse that arrives one tick late or that fires on the cycle before the match.

// File: rtl/cct_pkg.sv
package cct_pkg;
  localparam int unsigned NSLOT  = 8;
  localparam int unsigned CNT_W  = 16;
  localparam int unsigned ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h00;
  localparam logic [ADDR_W-1:0] A_MODE  = 6'h01;
  localparam logic [ADDR_W-1:0] A_EDGE0 = 6'h02;
  localparam logic [ADDR_W-1:0] A_EDGE1 = 6'h03;
  localparam logic [ADDR_W-1:0] A_CNTH  = 6'h04;
  localparam logic [ADDR_W-1:0] A_CNTL  = 6'h05;
  localparam logic [ADDR_W-1:0] A_FLAG1 = 6'h06;
  localparam logic [ADDR_W-1:0] A_FLAG2 = 6'h07;
  localparam int unsigned       CH_BASE = 16;

  localparam int unsigned CTRL_RUN_BIT = 7;
  localparam int unsigned CTRL_FCL_BIT = 0;
  localparam int unsigned OVF_BIT      = 7;

  typedef enum logic [1:0] {
    EDGE_OFF  = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_BOTH = 2'b11
  } edge_sel_e;
endpackage

// File: rtl/cct_edge_det.sv
module cct_edge_det
  import cct_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      din,
  input  edge_sel_e sel,
  output logic      hit
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic              rise, fall;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], din};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~prev_q;
  assign fall = ~sync_q[STAGES-1] & prev_q;

  always_comb begin
    unique case (sel)
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      EDGE_BOTH: hit = rise | fall;
      default:   hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/cct_counter.sv
module cct_counter #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         run,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt_q,
  output logic [W-1:0] cnt_nxt,
  output logic         step,
  output logic         wrap
);
  assign step    = run & ~load;
  assign cnt_nxt = cnt_q + W'(1);
  assign wrap    = step & (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (load) cnt_q <= load_val;
    else if (step) cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/cct_channel.sv
module cct_channel #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mode_cmp,
  input  logic         cap_hit,
  input  logic [W-1:0] cnt_q,
  input  logic [W-1:0] cnt_nxt,
  input  logic         step,
  input  logic         commit,
  input  logic [W-1:0] commit_val,
  output logic [W-1:0] val_q,
  output logic         evt,
  output logic         cmp_pulse
);
  logic cap_evt, cmp_evt;

  assign cap_evt = ~mode_cmp & cap_hit;
  assign cmp_evt = mode_cmp & step & (cnt_nxt == val_q);
  assign evt     = cap_evt | cmp_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      val_q     <= '0;
      cmp_pulse <= 1'b0;
    end else begin
      cmp_pulse <= cmp_evt;
      if (cap_evt)                val_q <= cnt_q;
      else if (mode_cmp && commit) val_q <= commit_val;
    end
  end
endmodule

// File: rtl/cct_timer.sv
module cct_timer
  import cct_pkg::*;
#(
  parameter int unsigned NCH_IMPL    = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tick,
  input  logic              pacc_en,
  input  logic [NSLOT-1:0]  cap_in,
  output logic [NSLOT-1:0]  cmp_out
);
  localparam logic [NSLOT-1:0] IMPL_MASK = NSLOT'((1 << NCH_IMPL) - 1);

  function automatic logic [2*NSLOT-1:0] edge_mask_f(input int unsigned n);
    logic [2*NSLOT-1:0] m;
    m = '0;
    for (int unsigned k = 0; k < NSLOT; k++)
      if (k < n) m[2*k +: 2] = 2'b11;
    return m;
  endfunction
  localparam logic [2*NSLOT-1:0] EDGE_MASK = edge_mask_f(NCH_IMPL);

  logic                          ctrl_run_q, ctrl_fcl_q;
  logic [NSLOT-1:0]              mode_q;
  logic [2*NSLOT-1:0]            edge_q;
  logic [NSLOT-1:0]              flag1_q;
  logic                          ovf_q;
  logic [7:0]                    wr_hi_buf, rd_shadow;
  logic [CNT_W-1:0]              cnt_q, cnt_nxt;
  logic                          cnt_step, cnt_wrap, cnt_load;
  logic [NSLOT-1:0][CNT_W-1:0]   chan_val;
  logic [NSLOT-1:0]              chan_evt;
  logic                          word_hit, word_lo, cnt_addr, wr_commit;
  logic [CNT_W-1:0]              commit_val, word_val;
  logic [7:0]                    reg_rd;
  logic                          ovf_clr;
  logic [NSLOT-1:0]              flag1_clr;

  // bus decode
  assign cnt_addr   = (bus_addr == A_CNTH) || (bus_addr == A_CNTL);
  assign word_hit   = cnt_addr || (bus_addr[5:4] == 2'b01);
  assign word_lo    = bus_addr[0];
  assign wr_commit  = bus_wr && word_hit && word_lo;
  assign commit_val = {wr_hi_buf, bus_wdata};
  assign cnt_load   = wr_commit && (bus_addr == A_CNTL);

  cct_counter #(.W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .run      (ctrl_run_q & tick),
    .load     (cnt_load),
    .load_val (commit_val),
    .cnt_q    (cnt_q),
    .cnt_nxt  (cnt_nxt),
    .step     (cnt_step),
    .wrap     (cnt_wrap)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_ch
    if (i < NCH_IMPL) begin : g_impl
      logic hit;
      logic commit_i;
      assign commit_i = wr_commit && (bus_addr == ADDR_W'(CH_BASE + 2*i + 1));

      cct_edge_det #(.STAGES(SYNC_STAGES)) u_edge (
        .clk (clk),
        .rst (rst),
        .din (cap_in[i]),
        .sel (edge_sel_e'(edge_q[2*i +: 2])),
        .hit (hit)
      );

      cct_channel #(.W(CNT_W)) u_chan (
        .clk        (clk),
        .rst        (rst),
        .mode_cmp   (mode_q[i]),
        .cap_hit    (hit),
        .cnt_q      (cnt_q),
        .cnt_nxt    (cnt_nxt),
        .step       (cnt_step),
        .commit     (commit_i),
        .commit_val (commit_val),
        .val_q      (chan_val[i]),
        .evt        (chan_evt[i]),
        .cmp_pulse  (cmp_out[i])
      );
    end else begin : g_rsvd
      assign chan_val[i] = '0;
      assign chan_evt[i] = 1'b0;
      assign cmp_out[i]  = 1'b0;
    end
  end

  // control registers and high-byte write buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_run_q <= 1'b0;
      ctrl_fcl_q <= 1'b0;
      mode_q     <= '0;
      edge_q     <= '0;
      wr_hi_buf  <= '0;
    end else if (bus_wr) begin
      if (bus_addr == A_CTRL) begin
        ctrl_run_q <= bus_wdata[CTRL_RUN_BIT];
        ctrl_fcl_q <= bus_wdata[CTRL_FCL_BIT];
      end
      if (bus_addr == A_MODE)  mode_q <= bus_wdata & IMPL_MASK;
      if (bus_addr == A_EDGE0) edge_q[7:0]  <= bus_wdata & EDGE_MASK[7:0];
      if (bus_addr == A_EDGE1) edge_q[15:8] <= bus_wdata & EDGE_MASK[15:8];
      if (word_hit && !word_lo) wr_hi_buf <= bus_wdata;
    end
  end

  // flags: set has priority over any clear in the same cycle
  assign flag1_clr = (bus_wr && bus_addr == A_FLAG1) ? bus_wdata : '0;
  assign ovf_clr   = (bus_wr && bus_addr == A_FLAG2 && bus_wdata[OVF_BIT] &&
                      (ctrl_run_q || pacc_en)) ||
                     (ctrl_fcl_q && (bus_rd || bus_wr) && cnt_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag1_q <= '0;
      ovf_q   <= 1'b0;
    end else begin
      flag1_q <= ((flag1_q & ~flag1_clr) | chan_evt) & IMPL_MASK;
      if (cnt_wrap)     ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
    end
  end

  // read path
  assign word_val = cnt_addr ? cnt_q : chan_val[bus_addr[3:1]];

  always_comb begin
    unique case (bus_addr)
      A_CTRL:  reg_rd = {ctrl_run_q, 6'b0, ctrl_fcl_q};
      A_MODE:  reg_rd = mode_q;
      A_EDGE0: reg_rd = edge_q[7:0];
      A_EDGE1: reg_rd = edge_q[15:8];
      A_FLAG1: reg_rd = flag1_q;
      A_FLAG2: reg_rd = {ovf_q, 7'b0};
      default: reg_rd = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      rd_shadow <= '0;
    end else if (bus_rd) begin
      if (word_hit && !word_lo) begin
        bus_rdata <= word_val[15:8];
        rd_shadow <= word_val[7:0];
      end else if (word_hit) begin
        bus_rdata <= rd_shadow;
      end else begin
        bus_rdata <= reg_rd;
      end
    end
  end
endmodule

// File: rtl/cct_timer_sva.sv
module cct_timer_sva
  import cct_pkg::*;
#(
  parameter int unsigned NCH_IMPL = 6
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [7:0]        bus_wdata,
  input logic [7:0]        bus_rdata,
  input logic              pacc_en,
  input logic              run_bit,
  input logic              fcl_bit,
  input logic [CNT_W-1:0]  cnt_q,
  input logic              cnt_step,
  input logic              cnt_load,
  input logic              ovf_q,
  input logic [NSLOT-1:0]  flag1_q,
  input logic [NSLOT-1:0]  cmp_out
);
  localparam int unsigned RSV_BASE = CH_BASE + 2*NCH_IMPL;

  // R1
  a_r1_reset_clean: assert property (@(posedge clk)
    $past(rst) && !rst |-> (cnt_q == '0 && !ovf_q && flag1_q == '0 && cmp_out == '0));

  // R2
  a_r2_hold_when_off: assert property (@(posedge clk) disable iff (rst)
    (!run_bit && !cnt_load) |=> $stable(cnt_q));

  // R3
  a_r3_wrap_sets_ovf: assert property (@(posedge clk) disable iff (rst)
    (cnt_step && cnt_q == '1) |=> ovf_q);

  // R4, R5
  a_r4_ovf_clear_gated: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_q) |-> $past((bus_wr && bus_addr == A_FLAG2 && bus_wdata[OVF_BIT] &&
                            (run_bit || pacc_en)) ||
                           (fcl_bit && (bus_rd || bus_wr) &&
                            (bus_addr == A_CNTH || bus_addr == A_CNTL))));

  // R7
  a_r7_pulse_has_flag: assert property (@(posedge clk) disable iff (rst)
    (cmp_out & ~flag1_q) == '0);

  // R11
  a_r11_reserved_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && int'(bus_addr) >= RSV_BASE && !bus_addr[0]) |=> bus_rdata == 8'h00);
endmodule

bind cct_timer cct_timer_sva #(.NCH_IMPL(NCH_IMPL)) u_sva (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pacc_en   (pacc_en),
  .run_bit   (ctrl_run_q),
  .fcl_bit   (ctrl_fcl_q),
  .cnt_q     (cnt_q),
  .cnt_step  (cnt_step),
  .cnt_load  (cnt_load),
  .ovf_q     (ovf_q),
  .flag1_q   (flag1_q),
  .cmp_out   (cmp_out)
);

// File: tb/cct_timer_tb_top.sv
module cct_timer_tb_top;
  import cct_pkg::*;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]        bus_wdata = '0;
  logic [7:0]        bus_rdata;
  logic              tick = 1'b0, pacc_en = 1'b0;
  logic [NSLOT-1:0]  cap_in = '0;
  logic [NSLOT-1:0]  cmp_out;

  int n_tests = 0;
  int n_fail  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_seen = 1'b0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  cct_timer #(.NCH_IMPL(6), .SYNC_STAGES(2)) dut_i (
    .clk, .rst, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .bus_rdata,
    .tick, .pacc_en, .cap_in, .cmp_out
  );

  // monitor: scoreboard of expected read bytes
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      logic [7:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_tests++;
      if (bus_rdata !== e) begin
        n_fail++;
        $display("FAIL %s: actual=%02h expected=%02h", t, bus_rdata, e);
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic wr16(input logic [5:0] ahi, input logic [15:0] v);
    wr(ahi, v[15:8]);
    wr(ahi + 6'd1, v[7:0]);
  endtask

  task automatic rd16(input logic [5:0] ahi, input logic [15:0] e, input string t);
    rd(ahi, e[15:8], t);
    rd(ahi + 6'd1, e[7:0], t);
  endtask

  task automatic ticks(input int n);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic chk(input logic act, input logic e, input string t);
    n_tests++;
    if (act !== e) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", t, act, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    idle(1);
    // R1: reset state
    chk(cmp_out[0], 1'b0, "R1 cmp_out low");
    rd16(A_CNTH, 16'h0000, "R1 counter reset");
    rd16(6'h10, 16'h0000, "R1 ch0 reset");
    rd(A_FLAG2, 8'h00, "R1 overflow flag reset");
    rd(A_FLAG1, 8'h00, "R1 channel flags reset");
    rd(A_MODE, 8'h00, "R1 mode reset");

    // R2: load, count, hold
    wr(A_CTRL, 8'h80);
    wr16(A_CNTH, 16'h1234);
    ticks(3);
    rd16(A_CNTH, 16'h1237, "R2 counts on tick");
    wr(A_CTRL, 8'h00);
    ticks(3);
    rd16(A_CNTH, 16'h1237, "R2 holds when disabled");

    // R10: high byte buffered until low byte
    wr(A_CNTH, 8'h55);
    rd(A_CNTH, 8'h12, "R10 high write buffered");
    wr(A_CNTL, 8'h66);
    rd16(A_CNTH, 16'h5566, "R10 commit on low write");

    // R3 / R4
    wr(A_CTRL, 8'h80);
    wr16(A_CNTH, 16'hFFFE);
    ticks(2);
    rd(A_FLAG2, 8'h80, "R3 overflow on wrap");
    rd16(A_CNTH, 16'h0000, "R3 counter wrapped");
    wr(A_CTRL, 8'h00);
    wr(A_FLAG2, 8'h80);
    rd(A_FLAG2, 8'h80, "R4 clear ignored without enable");
    pacc_en = 1'b1;
    wr(A_FLAG2, 8'h80);
    rd(A_FLAG2, 8'h00, "R4 clear via pacc_en");
    pacc_en = 1'b0;

    // R5: fast clear
    wr(A_CTRL, 8'h81);
    wr16(A_CNTH, 16'hFFFF);
    ticks(1);
    rd(A_FLAG2, 8'h80, "R5 flag set before access");
    rd(A_CNTH, 8'h00, "R5 counter access");
    rd(A_FLAG2, 8'h00, "R5 fast clear on counter read");
    wr(A_CTRL, 8'h80);
    wr16(A_CNTH, 16'hFFFF);
    ticks(1);
    rd(A_CNTH, 8'h00, "R5 counter access no fast clear");
    rd(A_FLAG2, 8'h80, "R5 flag kept without fast clear");
    wr(A_FLAG2, 8'h80);
    rd(A_FLAG2, 8'h00, "R4 clear with timer enabled");

    // R7 / R12: compare
    wr(A_MODE, 8'h01);
    wr16(6'h10, 16'h0005);
    wr16(A_CNTH, 16'h0003);
    ticks(1);
    chk(cmp_out[0], 1'b0, "R7 no pulse before match");
    ticks(1);
    chk(cmp_out[0], 1'b1, "R7 pulse on match");
    idle(1);
    chk(cmp_out[0], 1'b0, "R7 pulse one cycle");
    rd(A_FLAG1, 8'h01, "R7 compare flag");
    wr(A_FLAG1, 8'h00);
    rd(A_FLAG1, 8'h01, "R12 zero write keeps flag");
    wr(A_FLAG1, 8'h01);
    rd(A_FLAG1, 8'h00, "R12 write-one clears flag");
    rd16(6'h10, 16'h0005, "R8 compare value readable");

    // R8: capture-mode write ignored
    wr(A_MODE, 8'h00);
    wr(A_CTRL, 8'h00);
    wr16(6'h12, 16'hABCD);
    rd16(6'h12, 16'h0000, "R8 capture-mode write ignored");

    // R6: capture edges
    wr16(A_CNTH, 16'h2345);
    wr(A_EDGE0, 8'h34);            // ch1 rising, ch2 both, ch0 off
    cap_in[1] = 1'b1; idle(5);
    rd16(6'h12, 16'h2345, "R6 rising capture");
    rd(A_FLAG1, 8'h02, "R6 capture flag");
    wr(A_FLAG1, 8'hFF);
    wr16(A_CNTH, 16'h1111);
    cap_in[1] = 1'b0; idle(5);
    rd16(6'h12, 16'h2345, "R6 falling ignored on rising select");
    rd(A_FLAG1, 8'h00, "R6 no flag on unselected edge");
    cap_in[2] = 1'b1; idle(5);
    rd16(6'h14, 16'h1111, "R6 both-edge rising capture");
    wr16(A_CNTH, 16'h2222);
    cap_in[2] = 1'b0; idle(5);
    rd16(6'h14, 16'h2222, "R6 both-edge falling capture");
    cap_in[0] = 1'b1; idle(5);
    cap_in[0] = 1'b0; idle(5);
    rd16(6'h10, 16'h0005, "R6 edge code 00 disabled");
    wr(A_FLAG1, 8'hFF);

    // R11: reserved and last implemented slots
    wr(A_MODE, 8'hFF);
    rd(A_MODE, 8'h3F, "R11 reserved mode bits zero");
    wr16(6'h1C, 16'h7788);
    rd16(6'h1C, 16'h0000, "R11 reserved slot reads zero");
    wr16(6'h1A, 16'h9ABC);
    rd16(6'h1A, 16'h9ABC, "R11 channel 5 at 0x1A");

    // R9: coherent read across a tick
    wr(A_MODE, 8'h00);
    wr16(A_CNTH, 16'h12FF);
    wr(A_CTRL, 8'h80);
    rd(A_CNTH, 8'h12, "R9 high byte");
    ticks(1);
    rd(A_CNTL, 8'hFF, "R9 low from shadow");
    rd16(A_CNTH, 16'h1300, "R9 fresh pair");

    idle(3);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule